// File: doc/BRIEF.md
# Video Stream Capture Filter

This block sits on a parallel digital-video input that carries one data element per pixel clock in the BT.656 layout, with 8-bit or 10-bit elements. It searches the stream for timing reference preambles (a maximum-value word, two zero words, then a control word). It decodes field, vertical-blanking and horizontal-blanking flags from each control word. It then forwards on a valid/data pair only the words that the selected capture mode wants.

Three capture modes exist. The first keeps only active picture samples. The second keeps everything on vertical-blanking lines. The third keeps the whole stream. A mode change waits for the next start-of-active-video code, so a line is never split between two policies. Every word passes through a four-stage delay line. When a control word arrives, the three preamble words that came before it are still inside the delay line, so they can be reclassified as preamble. A false preamble (max, zero, then a non-zero word) therefore stays ordinary data.

The preamble detector is a four-state machine. IDLE goes to SAW_MAX on a maximum word. SAW_MAX goes to ZERO_ONE on a zero word, stays in SAW_MAX on another maximum word, and otherwise returns to IDLE. ZERO_ONE goes to ZERO_TWO on a zero word, to SAW_MAX on a maximum word, and otherwise to IDLE. ZERO_TWO treats the current word as the control word and always returns to IDLE.

Top module: `video_field_filter`

## Requirements
- R1: With `wide_mode`=1 the preamble is 0x3FF,0x000,0x000 on all ten bits, so 0x0FF,0x000,0x000 is plain data. With `wide_mode`=0 only `din[7:0]` is used: the preamble is 0xFF,0x00,0x00, the upper two input bits are ignored, and `out_data[9:8]` is zero.
- R2: The flags sit at fixed positions. In 10-bit mode field, vblank and hblank are bits 8, 7 and 6. In 8-bit mode they are bits 6, 5 and 4. `out_field`/`out_vblank`/`out_hblank` take the control word's values one clock after it is sampled, and they hold until the next control word.
- R3: When `mode_sel` is 00 (active only), a word is forwarded only if the latched vblank flag is 0 and the last control word was a start code (hblank=0). The four preamble words are never forwarded.
- R4: When `mode_sel` is 01 (vertical blanking only), a word is forwarded while the latched vblank flag is 1. The four preamble words are forwarded when their control word has vblank=1.
- R5: When `mode_sel` is 10 (whole field), every word after lock is forwarded, preambles included. The value 11 behaves exactly like 10.
- R6: A word sampled on a rising edge is presented on `out_data`/`out_valid` after the fourth rising edge counted from that one. Words leave in arrival order.
- R7: A new `mode_sel` value takes effect at the next control word with hblank=0, and it already governs that word's preamble. An end code (hblank=1) keeps the previous mode.
- R8: Synchronous active-high `rst` clears the flags and the delay line. Nothing is forwarded until the first complete preamble has been seen. That preamble's own words follow the mode rules.
- R9: A partial preamble that does not complete is ordinary data and is filtered as such.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 = 10-bit elements, 0 = 8-bit elements on din[7:0] |
| mode_sel | input | 2 | Capture mode: 00 active, 01 vertical blanking, 10/11 whole field |
| din | input | DATA_W (10) | Video element stream |
| out_valid | output | 1 | out_data holds a forwarded word |
| out_data | output | DATA_W (10) | Forwarded word (upper bits zero in 8-bit mode) |
| out_field | output | 1 | Latched field flag |
| out_vblank | output | 1 | Latched vertical-blanking flag |
| out_hblank | output | 1 | Latched horizontal-blanking flag (1 after end code) |

## Verification
A table-driven run walks a line sequence that moves through whole-field, active-only and blanking-only capture. Mode requests are placed just before end codes and start codes. This separates a mode that switches at the start code from one that switches early. Lines with vblank set and cleared show whether the latched vertical flag or the control word's own flag selects the preamble. A broken preamble (max, zero, non-zero) placed just before a real one shows whether reclassification reaches only completed preambles. Directed runs then feed 8-bit words with stray upper bits, a 10-bit stream containing an 8-bit-looking preamble, and unlocked data after a mid-stream reset in mode 11.

// File: rtl/vff_pkg.sv
package vff_pkg;

    // Capture policy selected by mode_sel
    typedef enum logic [1:0] {
        MODE_ACTIVE    = 2'b00,
        MODE_VBI       = 2'b01,
        MODE_FIELD     = 2'b10,
        MODE_FIELD_ALT = 2'b11
    } cap_mode_e;

    // Preamble search states
    typedef enum logic [1:0] {
        TRS_IDLE,
        TRS_SAW_MAX,
        TRS_ZERO_ONE,
        TRS_ZERO_TWO
    } trs_state_e;

    typedef struct packed {
        logic field;
        logic vblank;
        logic hblank;
    } trs_flags_t;

    // Words in one timing reference (max, zero, zero, control)
    localparam int PRE_LEN = 4;

endpackage

// File: rtl/vff_trs_fsm.sv
module vff_trs_fsm
    import vff_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] din,
    output logic              ctrl_hit,
    output trs_flags_t        ctrl_flags
);
    localparam int WIDE_TOP   = DATA_W - 1;
    localparam int NARROW_TOP = NARROW_W - 1;

    trs_state_e state_q;
    trs_state_e state_d;
    logic       is_max;
    logic       is_zero;

    // Word classification against the selected element width
    always_comb begin
        if (wide_mode) begin
            is_max  = &din;
            is_zero = ~|din;
        end else begin
            is_max  = &din[NARROW_TOP:0];
            is_zero = ~|din[NARROW_TOP:0];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRS_IDLE: begin
                if (is_max) state_d = TRS_SAW_MAX;
            end
            TRS_SAW_MAX: begin
                if (is_zero)     state_d = TRS_ZERO_ONE;
                else if (is_max) state_d = TRS_SAW_MAX;
                else             state_d = TRS_IDLE;
            end
            TRS_ZERO_ONE: begin
                if (is_zero)     state_d = TRS_ZERO_TWO;
                else if (is_max) state_d = TRS_SAW_MAX;
                else             state_d = TRS_IDLE;
            end
            TRS_ZERO_TWO: begin
                state_d = TRS_IDLE;
            end
        endcase
    end

    // Outputs: control word present now, and its decoded flags
    always_comb begin
        ctrl_hit = (state_q == TRS_ZERO_TWO);
        if (wide_mode) begin
            ctrl_flags.field  = din[WIDE_TOP-1];
            ctrl_flags.vblank = din[WIDE_TOP-2];
            ctrl_flags.hblank = din[WIDE_TOP-3];
        end else begin
            ctrl_flags.field  = din[NARROW_TOP-1];
            ctrl_flags.vblank = din[NARROW_TOP-2];
            ctrl_flags.hblank = din[NARROW_TOP-3];
        end
    end

endmodule

// File: rtl/vff_ctrl_track.sv
module vff_ctrl_track
    import vff_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       ctrl_hit,
    input  trs_flags_t ctrl_flags,
    output logic       locked,
    output trs_flags_t flags_q,
    output cap_mode_e  act_mode,
    output logic       sav_hit
);
    // A control word with hblank clear opens active video
    assign sav_hit = ctrl_hit && !ctrl_flags.hblank;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            flags_q  <= '0;
            act_mode <= MODE_ACTIVE;
        end else begin
            if (ctrl_hit) begin
                locked  <= 1'b1;
                flags_q <= ctrl_flags;
            end
            // Before lock the request is tracked; after lock only at a start code
            if (!locked || sav_hit) begin
                act_mode <= cap_mode_e'(mode_sel);
            end
        end
    end

endmodule

// File: rtl/vff_policy.sv
module vff_policy
    import vff_pkg::*;
(
    input  logic       locked,
    input  cap_mode_e  act_mode,
    input  logic [1:0] mode_sel,
    input  logic       cur_vblank,
    input  logic       cur_hblank,
    input  logic       new_vblank,
    input  logic       new_hblank,
    output logic       fwd_word,
    output logic       fwd_pre
);
    cap_mode_e pre_mode;

    // Decision for an ordinary word under the latched state
    always_comb begin
        fwd_word = 1'b0;
        if (locked) begin
            unique case (act_mode)
                MODE_ACTIVE:    fwd_word = !cur_vblank && !cur_hblank;
                MODE_VBI:       fwd_word = cur_vblank;
                MODE_FIELD,
                MODE_FIELD_ALT: fwd_word = 1'b1;
            endcase
        end
    end

    // Decision for a completed preamble, using its own control word
    always_comb begin
        if (!locked || !new_hblank) pre_mode = cap_mode_e'(mode_sel);
        else                        pre_mode = act_mode;
        fwd_pre = 1'b0;
        unique case (pre_mode)
            MODE_ACTIVE:    fwd_pre = 1'b0;
            MODE_VBI:       fwd_pre = new_vblank;
            MODE_FIELD,
            MODE_FIELD_ALT: fwd_pre = 1'b1;
        endcase
    end

endmodule

// File: rtl/vff_delay_gate.sv
module vff_delay_gate
    import vff_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int DEPTH  = PRE_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              ctrl_hit,
    input  logic              fwd_word,
    input  logic              fwd_pre,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int LAST = DEPTH - 1;

    logic [DATA_W-1:0] dat_q [DEPTH];
    logic [DEPTH-1:0]  fwd_q;
    logic [DEPTH-1:0]  pre_span;

    // Stages that hold a word of the preamble that is completing now
    for (genvar i = 0; i < DEPTH; i++) begin : g_span
        if (i < PRE_LEN) begin : g_in
            assign pre_span[i] = 1'b1;
        end else begin : g_out
            assign pre_span[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
            fwd_q <= '0;
        end else begin
            dat_q[0] <= din;
            fwd_q[0] <= ctrl_hit ? fwd_pre : fwd_word;
            for (int i = 1; i < DEPTH; i++) begin
                dat_q[i] <= dat_q[i-1];
                fwd_q[i] <= (ctrl_hit && pre_span[i]) ? fwd_pre : fwd_q[i-1];
            end
        end
    end

    assign out_valid = fwd_q[LAST];
    assign out_data  = dat_q[LAST];

endmodule

// File: rtl/video_field_filter.sv
module video_field_filter
    import vff_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic [1:0]        mode_sel,
    input  logic [DATA_W-1:0] din,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_field,
    output logic              out_vblank,
    output logic              out_hblank
);
    localparam int PAD_W = DATA_W - NARROW_W;

    logic              ctrl_hit;
    trs_flags_t        ctrl_flags;
    logic              locked;
    trs_flags_t        flags_q;
    cap_mode_e         act_mode;
    logic              sav_hit;
    logic              fwd_word;
    logic              fwd_pre;
    logic [DATA_W-1:0] din_eff;

    // Narrow elements lose the unused upper bits before storage
    assign din_eff = wide_mode ? din : {{PAD_W{1'b0}}, din[NARROW_W-1:0]};

    vff_trs_fsm #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_trs (
        .clk        (clk),
        .rst        (rst),
        .wide_mode  (wide_mode),
        .din        (din),
        .ctrl_hit   (ctrl_hit),
        .ctrl_flags (ctrl_flags)
    );

    vff_ctrl_track u_track (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .ctrl_hit   (ctrl_hit),
        .ctrl_flags (ctrl_flags),
        .locked     (locked),
        .flags_q    (flags_q),
        .act_mode   (act_mode),
        .sav_hit    (sav_hit)
    );

    vff_policy u_policy (
        .locked     (locked),
        .act_mode   (act_mode),
        .mode_sel   (mode_sel),
        .cur_vblank (flags_q.vblank),
        .cur_hblank (flags_q.hblank),
        .new_vblank (ctrl_flags.vblank),
        .new_hblank (ctrl_flags.hblank),
        .fwd_word   (fwd_word),
        .fwd_pre    (fwd_pre)
    );

    vff_delay_gate #(.DATA_W(DATA_W), .DEPTH(PRE_LEN)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .din       (din_eff),
        .ctrl_hit  (ctrl_hit),
        .fwd_word  (fwd_word),
        .fwd_pre   (fwd_pre),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign out_field  = flags_q.field;
    assign out_vblank = flags_q.vblank;
    assign out_hblank = flags_q.hblank;

endmodule

// File: rtl/vff_checker.sv
module vff_checker #(
    parameter int DATA_W   = 10,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wide_mode,
    input logic [DATA_W-1:0] din,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_field,
    input logic              out_vblank,
    input logic              out_hblank,
    input logic              locked,
    input logic              ctrl_hit,
    input logic              sav_hit,
    input logic [1:0]        act_mode
);
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(wide_mode, 4)) |-> (out_data[DATA_W-1:NARROW_W] == '0)); // R1

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(ctrl_hit) && !$past(rst)) |-> $stable({out_field, out_vblank, out_hblank})); // R2

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(locked) && !$past(sav_hit) && !$past(rst)) |-> $stable(act_mode)); // R7

    AST_NO_OUT_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !locked |-> !out_valid); // R8

    AST_CTRL_AFTER_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit |-> ($past(din[NARROW_W-1:0], 1) == '0 &&
                      $past(din[NARROW_W-1:0], 2) == '0 &&
                      &$past(din[NARROW_W-1:0], 3))); // R9

endmodule

bind video_field_filter vff_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wide_mode  (wide_mode),
    .din        (din),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_field  (out_field),
    .out_vblank (out_vblank),
    .out_hblank (out_hblank),
    .locked     (locked),
    .ctrl_hit   (ctrl_hit),
    .sav_hit    (sav_hit),
    .act_mode   (act_mode)
);

// File: tb/video_field_filter_test.sv
module video_field_filter_test;
    localparam int W = 10;
    localparam int NV = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wide_mode = 1'b1;
    logic [1:0]   mode_sel = 2'b10;
    logic [W-1:0] din = '0;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         out_field;
    logic         out_vblank;
    logic         out_hblank;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    video_field_filter uut (
        .clk        (clk),
        .rst        (rst),
        .wide_mode  (wide_mode),
        .mode_sel   (mode_sel),
        .din        (din),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_field  (out_field),
        .out_vblank (out_vblank),
        .out_hblank (out_hblank)
    );

    // {mode_sel, expected valid, word}; expected output appears four steps later
    localparam logic [12:0] VEC [NV] = '{
        {2'd2,1'b0,10'h123}, {2'd2,1'b1,10'h3FF}, {2'd2,1'b1,10'h000}, {2'd2,1'b1,10'h000},
        {2'd2,1'b1,10'h240}, {2'd2,1'b1,10'h010}, {2'd2,1'b1,10'h3FF}, {2'd2,1'b1,10'h000},
        {2'd2,1'b1,10'h000}, {2'd2,1'b1,10'h200}, {2'd2,1'b1,10'h155},
        // request active-only; end code keeps whole field (R7)
        {2'd0,1'b1,10'h3FF}, {2'd0,1'b1,10'h000}, {2'd0,1'b1,10'h000}, {2'd0,1'b1,10'h240},
        {2'd0,1'b1,10'h020},
        // start code applies active-only to its own preamble
        {2'd0,1'b0,10'h3FF}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h200},
        {2'd0,1'b1,10'h101},
        {2'd0,1'b0,10'h3FF}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h240},
        {2'd0,1'b0,10'h030},
        // vertical blanking line under active-only
        {2'd0,1'b0,10'h3FF}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h280},
        {2'd0,1'b0,10'h040},
        // request blanking-only
        {2'd1,1'b0,10'h3FF}, {2'd1,1'b0,10'h000}, {2'd1,1'b0,10'h000}, {2'd1,1'b0,10'h2C0},
        {2'd1,1'b0,10'h050},
        {2'd1,1'b1,10'h3FF}, {2'd1,1'b1,10'h000}, {2'd1,1'b1,10'h000}, {2'd1,1'b1,10'h280},
        {2'd1,1'b1,10'h060},
        {2'd1,1'b1,10'h3FF}, {2'd1,1'b1,10'h000}, {2'd1,1'b1,10'h000}, {2'd1,1'b1,10'h2C0},
        {2'd1,1'b0,10'h3FF}, {2'd1,1'b0,10'h000}, {2'd1,1'b0,10'h000}, {2'd1,1'b0,10'h200},
        // back to active-only
        {2'd0,1'b0,10'h3FF}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h240},
        {2'd0,1'b0,10'h3FF}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h200},
        // broken preamble is picture data (R9), then a real end code
        {2'd0,1'b1,10'h3FF}, {2'd0,1'b1,10'h000}, {2'd0,1'b1,10'h155},
        {2'd0,1'b0,10'h3FF}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h000}, {2'd0,1'b0,10'h240}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [W-1:0] w);
        din = w;
        @(negedge clk);
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // R8: reset state
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R8 reset valid", out_valid, 0);
        check({out_field, out_vblank, out_hblank} == 3'b000, "R8 reset flags",
              {out_field, out_vblank, out_hblank}, 0);
        rst = 1'b0;

        // Table walk: R3 R4 R5 R6 R7 R9
        for (int j = 0; j < NV + 4; j++) begin
            if (j >= 4) begin
                logic [12:0] v;
                string tag;
                v = VEC[j-4];
                case (v[12:11])
                    2'd0:    tag = "R3 R6 table";
                    2'd1:    tag = "R4 R6 table";
                    default: tag = "R5 R6 table";
                endcase
                check(out_valid == v[10], tag, out_valid, v[10]);
                if (v[10]) check(out_data == v[9:0], tag, out_data, v[9:0]);
            end
            if (j < NV) begin
                mode_sel = VEC[j][12:11];
                step(VEC[j][9:0]);
            end else begin
                step(10'h0AA);
            end
        end
        // R2: last control word was an end code, field 0, vblank 0
        check({out_field, out_vblank, out_hblank} == 3'b001, "R2 table flags",
              {out_field, out_vblank, out_hblank}, 3'b001);

        // R1 R2: 8-bit elements with stray upper bits
        wide_mode = 1'b0;
        mode_sel  = 2'b10;
        reset_dut();
        step(10'h1FF); step(10'h100); step(10'h200);
        check({out_field, out_vblank, out_hblank} == 3'b000, "R2 hold on partial",
              {out_field, out_vblank, out_hblank}, 0);
        step(10'h3C0);
        check({out_field, out_vblank, out_hblank} == 3'b100, "R2 narrow flags",
              {out_field, out_vblank, out_hblank}, 3'b100);
        check(out_valid && out_data == 10'h0FF, "R1 narrow max word", out_data, 10'h0FF);
        step(10'h3AB);
        check(out_valid && out_data == 10'h000, "R1 narrow zero word", out_data, 10'h000);
        step(10'h000); step(10'h000); step(10'h000);
        check(out_valid && out_data == 10'h0AB, "R1 narrow data strip", out_data, 10'h0AB);

        // R1: 8-bit-looking preamble inside a 10-bit stream is data
        wide_mode = 1'b1;
        mode_sel  = 2'b00;
        reset_dut();
        step(10'h3FF); step(10'h000); step(10'h000); step(10'h200);
        step(10'h0FF); step(10'h000); step(10'h000); step(10'h240);
        check(out_valid && out_data == 10'h0FF, "R1 wide not preamble", out_data, 10'h0FF);
        check(out_hblank == 1'b0, "R1 wide no decode", out_hblank, 0);
        step(10'h000); step(10'h000); step(10'h000);
        check(out_valid && out_data == 10'h240, "R1 wide data tail", out_data, 10'h240);

        // R8: reset mid-stream, then unlocked data is held back
        rst = 1'b1;
        @(negedge clk);
        check({out_field, out_vblank, out_hblank} == 3'b000, "R8 mid reset flags",
              {out_field, out_vblank, out_hblank}, 0);
        check(out_valid == 1'b0, "R8 mid reset valid", out_valid, 0);
        rst = 1'b0;
        mode_sel = 2'b11;
        for (int k = 0; k < 4; k++) begin
            step(10'h111 + 10'(k));
            check(out_valid == 1'b0, "R8 unlocked data", out_valid, 0);
        end
        // R5: mode 11 acts as whole field
        step(10'h3FF); step(10'h000); step(10'h000); step(10'h2C0);
        check(out_valid && out_data == 10'h3FF, "R5 mode 11 preamble", out_data, 10'h3FF);
        step(10'h1CC); step(10'h000); step(10'h000); step(10'h000);
        check(out_valid && out_data == 10'h1CC, "R5 mode 11 data", out_data, 10'h1CC);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule